// File: doc/BRIEF.md
# Reset supervisor with watchdog

This block generates the system reset for a microcontroller subsystem. Three causes can request reset: a power-good flag dropping low, an active-low manual reset button, and a watchdog that expires when software stops servicing it. Whatever the cause, the reset output is held for a fixed recovery interval after the last cause disappears. All timing is counted in clock cycles, so the same code covers simulation-sized and real-time settings.

The button and service inputs are asynchronous. Each passes through a multi-flop synchronizer. The button is then debounced internally, so a bare mechanical switch can drive it. Software services the watchdog by toggling the service input, and either edge counts. The watchdog count is held at zero for as long as reset is asserted, and it starts counting on the cycle reset is released. A static enable input stands in for a floating service pin: when it is low, the watchdog can never cause a reset. The power-good input is taken as synchronous to the clock.

Top module: `rst_supervisor`

## Requirements
- R1: While `rst` is high, `sys_rst` is 1 and `sys_rst_n` is 0. At every clock `sys_rst_n` is the complement of `sys_rst`.
- R2: A low `pwr_ok` sampled on a clock edge makes `sys_rst` 1 from that edge.
- R3: Once `pwr_ok` is high again with no other cause present, `sys_rst` stays 1 for exactly `HOLD_CYC` further edges and falls on the `HOLD_CYC`-th one.
- R4: After synchronization, `man_rst_n` must stay low for `DEBOUNCE_CYC` consecutive cycles before it asserts reset. Shorter low pulses and bounce trains have no effect on `sys_rst`.
- R5: Reset stays asserted while the debounced button is low. It is released `HOLD_CYC` edges after the debounced button returns high.
- R6: With the watchdog enabled and no service edge, `sys_rst` rises `WD_TIMEOUT_CYC + 1` edges after it fell.
- R7: A reset caused by the watchdog lasts exactly `HOLD_CYC` cycles.
- R8: Both a 0-to-1 and a 1-to-0 transition of `wd_kick` restart the watchdog count.
- R9: While `sys_rst` is 1, the watchdog count is zero and ignores `wd_kick`. It counts from the release edge.
- R10: While `wd_en` is 0, the watchdog never asserts reset, however long `wd_kick` stays idle.
- R11: A new cause that appears during the recovery interval restarts the full interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| pwr_ok | input | 1 | Supply-good flag, low requests reset |
| man_rst_n | input | 1 | Asynchronous push-button, active low |
| wd_kick | input | 1 | Asynchronous watchdog service input, either edge services |
| wd_en | input | 1 | Watchdog enable, low models an undriven service pin |
| sys_rst_n | output | 1 | Registered reset output, active low |
| sys_rst | output | 1 | Registered reset output, active high |

## Verification
The bench measures the release edge exactly, to the cycle. A design with a counter that is off by one would release a cycle early or late, and a design that did not restart the interval on a second power dip would release while that dip was still being recovered from. Button pulses shorter than the debounce window, and bounce trains made of such pulses, must leave the output untouched; a filter that summed the low cycles instead of requiring a consecutive run would fire on them. The service input is toggled at three quarters of the timeout, so a watchdog that only honoured one edge polarity would expire. Kicks are also applied during a reset longer than the timeout, and the first expiry after release is timed exactly: a watchdog that counted or listened to kicks during reset would expire at a different cycle.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

  typedef enum logic {
    HS_RUN  = 1'b0,
    HS_HOLD = 1'b1
  } hold_state_t;

endpackage

// File: rtl/rsv_sync.sv
module rsv_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= {STAGES{RST_VAL}};
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/rsv_debounce.sv
module rsv_debounce #(
  parameter int   CYCLES   = 16,
  parameter logic IDLE_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] run_cnt;

  // A new level is taken only after CYCLES consecutive samples differ
  // from the accepted one; any return to the accepted level restarts.
  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
      dout    <= IDLE_VAL;
    end else if (din == dout) begin
      run_cnt <= '0;
    end else if (run_cnt == LAST) begin
      run_cnt <= '0;
      dout    <= din;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/rsv_watchdog.sv
module rsv_watchdog #(
  parameter int TIMEOUT = 1000,
  parameter int CW      = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          freeze,
  input  logic          kick_s,
  output logic          bite,
  output logic [CW-1:0] count
);

  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic kick_d;
  logic kick_edge;

  assign kick_edge = kick_s ^ kick_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      kick_d <= 1'b0;
      count  <= '0;
      bite   <= 1'b0;
    end else begin
      kick_d <= kick_s;
      bite   <= 1'b0;
      if (freeze || !en || kick_edge) begin
        count <= '0;
      end else if (count == LAST) begin
        count <= '0;
        bite  <= 1'b1;
      end else begin
        count <= count + 1'b1;
      end
    end
  end

endmodule

// File: rtl/rsv_stretch.sv
module rsv_stretch
  import rsv_pkg::*;
#(
  parameter int HOLD = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic cause,
  output logic rst_hi,
  output logic rst_lo
);

  localparam int CW = (HOLD < 2) ? 1 : $clog2(HOLD + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  hold_state_t   state;
  logic [CW-1:0] hold_cnt;

  always_ff @(posedge clk) begin
    if (rst || cause) begin
      state    <= HS_HOLD;
      hold_cnt <= '0;
      rst_hi   <= 1'b1;
      rst_lo   <= 1'b0;
    end else if (state == HS_HOLD) begin
      if (hold_cnt == LAST) begin
        state    <= HS_RUN;
        hold_cnt <= '0;
        rst_hi   <= 1'b0;
        rst_lo   <= 1'b1;
      end else begin
        hold_cnt <= hold_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int SYNC_STAGES    = 2,
  parameter int DEBOUNCE_CYC   = 2_500_000,
  parameter int HOLD_CYC       = 50_000_000,
  parameter int WD_TIMEOUT_CYC = 400_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_ok,
  input  logic man_rst_n,
  input  logic wd_kick,
  input  logic wd_en,
  output logic sys_rst_n,
  output logic sys_rst
);

  localparam int WD_W = $clog2(WD_TIMEOUT_CYC + 1);

  logic            mr_sync;
  logic            kick_sync;
  logic            mr_db;
  logic            wd_bite;
  logic            cause;
  logic [WD_W-1:0] wd_count;

  rsv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_mr_sync (
    .clk(clk), .rst(rst), .d(man_rst_n), .q(mr_sync)
  );

  rsv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_kick_sync (
    .clk(clk), .rst(rst), .d(wd_kick), .q(kick_sync)
  );

  rsv_debounce #(.CYCLES(DEBOUNCE_CYC), .IDLE_VAL(1'b1)) u_mr_db (
    .clk(clk), .rst(rst), .din(mr_sync), .dout(mr_db)
  );

  rsv_watchdog #(.TIMEOUT(WD_TIMEOUT_CYC), .CW(WD_W)) u_wd (
    .clk(clk), .rst(rst), .en(wd_en), .freeze(sys_rst),
    .kick_s(kick_sync), .bite(wd_bite), .count(wd_count)
  );

  assign cause = !pwr_ok || !mr_db || wd_bite;

  rsv_stretch #(.HOLD(HOLD_CYC)) u_hold (
    .clk(clk), .rst(rst), .cause(cause),
    .rst_hi(sys_rst), .rst_lo(sys_rst_n)
  );

endmodule

// File: rtl/rsv_checker.sv
module rsv_checker #(
  parameter int WD_W           = 10,
  parameter int WD_TIMEOUT_CYC = 1000
) (
  input logic            clk,
  input logic            rst,
  input logic            pwr_ok,
  input logic            wd_en,
  input logic            sys_rst,
  input logic            sys_rst_n,
  input logic            mr_sync,
  input logic            mr_db,
  input logic            wd_bite,
  input logic [WD_W-1:0] wd_count,
  input logic            cause
);

  // R1
  rst_pair_chk: assert property (@(posedge clk) disable iff (rst)
    sys_rst_n == !sys_rst);

  // R2
  pwr_low_chk: assert property (@(posedge clk) disable iff (rst)
    !pwr_ok |=> sys_rst);

  // R3
  release_clean_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_rst) |-> $past(!cause));

  // R4
  db_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(mr_db) |-> $past(!mr_sync));

  // R5
  mr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !mr_db |=> sys_rst);

  // R6
  wd_range_chk: assert property (@(posedge clk) disable iff (rst)
    wd_count < WD_W'(WD_TIMEOUT_CYC));

  // R7
  bite_rst_chk: assert property (@(posedge clk) disable iff (rst)
    wd_bite |=> sys_rst);

  // R9
  wd_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    sys_rst |=> (wd_count == '0));

  // R10
  wd_off_chk: assert property (@(posedge clk) disable iff (rst)
    !wd_en |=> !wd_bite);

endmodule

bind rst_supervisor rsv_checker #(
  .WD_W(WD_W),
  .WD_TIMEOUT_CYC(WD_TIMEOUT_CYC)
) u_chk (
  .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .wd_en(wd_en),
  .sys_rst(sys_rst), .sys_rst_n(sys_rst_n), .mr_sync(mr_sync),
  .mr_db(mr_db), .wd_bite(wd_bite), .wd_count(wd_count), .cause(cause)
);

// File: tb/sim_rst_supervisor.sv
`timescale 1ns/1ps
module sim_rst_supervisor;

  localparam int DB   = 4;
  localparam int HOLD = 8;
  localparam int WD   = 40;
  localparam int NV   = 18;

  // {pwr_ok, man_rst_n, cycles[7:0], expected sys_rst, req[3:0]}
  localparam logic [14:0] VEC [NV] = '{
    {1'b0, 1'b1, 8'd1,  1'b1, 4'd2},
    {1'b1, 1'b1, 8'd7,  1'b1, 4'd3},
    {1'b1, 1'b1, 8'd1,  1'b0, 4'd3},
    {1'b1, 1'b0, 8'd2,  1'b0, 4'd4},
    {1'b1, 1'b1, 8'd10, 1'b0, 4'd4},
    {1'b1, 1'b0, 8'd3,  1'b0, 4'd4},
    {1'b1, 1'b1, 8'd1,  1'b0, 4'd4},
    {1'b1, 1'b0, 8'd3,  1'b0, 4'd4},
    {1'b1, 1'b1, 8'd10, 1'b0, 4'd4},
    {1'b1, 1'b0, 8'd8,  1'b1, 4'd4},
    {1'b1, 1'b0, 8'd20, 1'b1, 4'd5},
    {1'b1, 1'b1, 8'd13, 1'b1, 4'd5},
    {1'b1, 1'b1, 8'd1,  1'b0, 4'd5},
    {1'b0, 1'b1, 8'd1,  1'b1, 4'd11},
    {1'b1, 1'b1, 8'd4,  1'b1, 4'd11},
    {1'b0, 1'b1, 8'd1,  1'b1, 4'd11},
    {1'b1, 1'b1, 8'd7,  1'b1, 4'd11},
    {1'b1, 1'b1, 8'd1,  1'b0, 4'd11}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_ok = 1'b1;
  logic man_rst_n = 1'b1;
  logic wd_kick = 1'b0;
  logic wd_en = 1'b0;
  logic sys_rst_n;
  logic sys_rst;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rst_supervisor #(
    .SYNC_STAGES(2), .DEBOUNCE_CYC(DB), .HOLD_CYC(HOLD), .WD_TIMEOUT_CYC(WD)
  ) u0 (
    .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .man_rst_n(man_rst_n),
    .wd_kick(wd_kick), .wd_en(wd_en), .sys_rst_n(sys_rst_n), .sys_rst(sys_rst)
  );

  function automatic string req_name(input logic [3:0] id);
    case (id)
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired, run hung");
    finish_run();
  end

  initial begin
    int n;
    int bad;
    @(negedge clk);
    tick(5);
    // R1: reset state
    check("R1 sys_rst in reset", int'(sys_rst), 1);
    check("R1 sys_rst_n in reset", int'(sys_rst_n), 0);
    rst = 1'b0;
    tick(HOLD + 5);
    check("R3 released after block reset", int'(sys_rst), 0);
    check("R1 complement", int'(sys_rst_n), 1);

    // Vector walk, watchdog disabled
    for (int v = 0; v < NV; v++) begin
      pwr_ok    = VEC[v][14];
      man_rst_n = VEC[v][13];
      tick(int'(VEC[v][12:5]));
      check(req_name(VEC[v][3:0]), int'(sys_rst), int'(VEC[v][4]));
    end

    // R9: long reset with kicks, then exact first expiry
    pwr_ok = 1'b0;
    wd_en  = 1'b1;
    for (int k = 0; k < 6; k++) begin
      tick(10);
      wd_kick = ~wd_kick;
    end
    tick(2);
    pwr_ok = 1'b1;
    tick(HOLD - 1);
    check("R3 held before release", int'(sys_rst), 1);
    tick(1);
    check("R3 released", int'(sys_rst), 0);
    n = 0;
    while (!sys_rst && n < WD + 20) begin
      tick(1);
      n++;
    end
    check("R6 R9 expiry cycles after release", n, WD + 1);
    n = 0;
    while (sys_rst && n < HOLD + 20) begin
      tick(1);
      n++;
    end
    check("R7 watchdog reset length", n, HOLD);

    // R8: toggle at 3/4 of timeout, alternating edge polarity
    bad = 0;
    for (int k = 0; k < 10; k++) begin
      for (int c = 0; c < (WD * 3) / 4; c++) begin
        tick(1);
        if (sys_rst) bad++;
      end
      wd_kick = ~wd_kick;
    end
    check("R8 both edges service", bad, 0);
    n = 0;
    while (!sys_rst && n < WD + 20) begin
      tick(1);
      n++;
    end
    check("R6 expiry after servicing stops", int'(n >= WD && n <= WD + 4), 1);

    // R10: watchdog disabled never fires
    n = 0;
    while (sys_rst && n < HOLD + 20) begin
      tick(1);
      n++;
    end
    wd_en = 1'b0;
    bad = 0;
    for (int c = 0; c < 8 * WD; c++) begin
      tick(1);
      if (sys_rst) bad++;
    end
    check("R10 no reset while disabled", bad, 0);
    check("R1 complement at end", int'(sys_rst_n), 1);

    finish_run();
  end

endmodule